// File: doc/BRIEF.md
# Dual-Enable Static RAM Model

This block is a synthesizable behavioural model of a byte-wide static RAM with one bidirectional data port. Four control inputs set what it does. One select is active low and one is active high, and the device is selected only when both are at their active level. An active-low read strobe and an active-low write strobe complete the control set. Together the four inputs choose one of four modes: deselected, output-off, read and write. The model drives the data pins only in read mode. In every other mode the pins are at high impedance.

A write is stored on the rising clock edge in any cycle where write mode is decoded. A write strobe that is low takes priority over the read strobe. Read data follows the address combinationally. The storage is built from a power-of-two number of banks. A parameter sets how bank selection is taken from the address. With interleaving, the lowest address bits choose the bank, so consecutive bytes fall into neighbouring banks. Without it, the highest bits choose the bank, so each bank holds one contiguous range. In both cases the memory behaves as one linear byte array. Setting the address width to 17 gives the full 128K-byte part. The smaller default keeps elaboration light.

Top module: `sram_dual_enable`

## Requirements
- R1: While `sel_lo_n` is 1, the device is deselected: `dq_drive` is 0, `dq` floats and no byte is written, whatever the other controls are.
- R2: While `sel_hi` is 0, the device is deselected with the same effect as in R1.
- R3: When selected with `read_en_n`=1 and `write_en_n`=1, the device is in output-off mode: `dq` floats and memory is unchanged.
- R4: When selected with `read_en_n`=0 and `write_en_n`=1, `dq` carries the byte stored at `addr`, and this follows `addr` with no clock delay.
- R5: When selected with `write_en_n`=0, the byte on `dq` is stored at `addr` on the rising edge of `clk`. This holds for either value of `read_en_n`, and the device does not drive `dq` in this mode.
- R6: A write changes only the addressed byte. All other locations keep their contents.
- R7: While `rst_n` is 0, no write is stored. Stored contents are kept through reset, and read mode still drives `dq`.
- R8: The value of `BANK_INTERLEAVE` (1 = bank taken from the low address bits, 0 = bank taken from the high bits) has no effect on what is read back from any linear address.
- R9: `dq_drive` is 1 exactly when read mode is decoded, and 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are stored on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| addr | input | ADDR_W | Byte address |
| sel_lo_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| read_en_n | input | 1 | Read (output) strobe, active low |
| write_en_n | input | 1 | Write strobe, active low; takes priority over read |
| dq | inout | DATA_W | Bidirectional data pins |
| dq_drive | output | 1 | High while the model drives `dq` |

## Verification
The bench builds two copies with a 10-bit address, 8-bit data and four banks. One copy interleaves the banks and the other stacks them contiguously. Both copies receive the same stimulus and are compared with one behavioural byte array. Four banks are enough to reach every bank-boundary and bank-wrap address in both layouts. The 1024-byte depth keeps a complete fill, directed corner cases at the first and last address, and several thousand random control combinations well inside the cycle budget.

// File: rtl/sram_model_pkg.sv
`timescale 1ns/1ps
package sram_model_pkg;

   typedef enum logic [1:0] {
      MODE_DESELECT = 2'd0,
      MODE_OUT_OFF  = 2'd1,
      MODE_READ     = 2'd2,
      MODE_WRITE    = 2'd3
   } sram_mode_e;

endpackage

// File: rtl/sram_mode_decode.sv
`timescale 1ns/1ps
module sram_mode_decode
   import sram_model_pkg::*;
(
   input  logic       sel_lo_n,
   input  logic       sel_hi,
   input  logic       read_en_n,
   input  logic       write_en_n,
   output sram_mode_e mode
);

   logic selected;

   assign selected = !sel_lo_n && sel_hi;

   always_comb begin
      if (!selected)
         mode = MODE_DESELECT;
      else if (!write_en_n)
         mode = MODE_WRITE;
      else if (!read_en_n)
         mode = MODE_READ;
      else
         mode = MODE_OUT_OFF;
   end

endmodule

// File: rtl/sram_bank.sv
`timescale 1ns/1ps
module sram_bank #(
   parameter int ROW_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ROW_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         cells[row] <= wdata;
   end

   assign rdata = cells[row];

endmodule

// File: rtl/sram_bank_array.sv
`timescale 1ns/1ps
module sram_bank_array #(
   parameter int ADDR_W          = 10,
   parameter int DATA_W          = 8,
   parameter int NUM_BANKS       = 4,
   parameter bit BANK_INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int BANK_W = $clog2(NUM_BANKS);
   localparam int ROW_W  = ADDR_W - BANK_W;

   logic [BANK_W-1:0]    bank_idx;
   logic [ROW_W-1:0]     row_idx;
   logic [NUM_BANKS-1:0] bank_we;
   logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

   generate
      if (BANK_INTERLEAVE) begin : g_interleave
         assign bank_idx = addr[BANK_W-1:0];
         assign row_idx  = addr[ADDR_W-1:BANK_W];
      end else begin : g_contiguous
         assign bank_idx = addr[ADDR_W-1:ROW_W];
         assign row_idx  = addr[ROW_W-1:0];
      end
   endgenerate

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_we[b] = wr_req && rst_n && (bank_idx == BANK_W'(b));

         sram_bank #(
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
         ) u_bank (
            .clk   (clk),
            .wr_en (bank_we[b]),
            .row   (row_idx),
            .wdata (wr_data),
            .rdata (bank_rd[b])
         );
      end
   endgenerate

   assign rd_data = bank_rd[bank_idx];

   // R6: at most one bank takes a given write
   p_single_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));

   // R5: a stored byte is seen on the read path one cycle later at the same address
   p_write_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> (($past(addr) == addr) -> (rd_data == $past(wr_data))));

   // R6: a cycle with no write leaves the byte at a held address unchanged
   p_hold_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> (($past(addr) == addr) -> (rd_data == $past(rd_data))));

endmodule

// File: rtl/sram_dual_enable.sv
`timescale 1ns/1ps
module sram_dual_enable
   import sram_model_pkg::*;
#(
   parameter int ADDR_W          = 10,
   parameter int DATA_W          = 8,
   parameter int NUM_BANKS       = 4,
   parameter bit BANK_INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel_lo_n,
   input  logic              sel_hi,
   input  logic              read_en_n,
   input  logic              write_en_n,
   inout  wire  [DATA_W-1:0] dq,
   output logic              dq_drive
);

   generate
      if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr_w
         $error("sram_dual_enable: ADDR_W out of range 2..24");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("sram_dual_enable: DATA_W must be positive");
      end
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("sram_dual_enable: NUM_BANKS must be a power of two >= 2");
      end
      if ($clog2(NUM_BANKS) >= ADDR_W) begin : g_bad_split
         $error("sram_dual_enable: NUM_BANKS leaves no row bits");
      end
   endgenerate

   sram_mode_e        mode;
   logic [DATA_W-1:0] rd_byte;
   logic [DATA_W-1:0] pin_data;

   sram_mode_decode u_decode (
      .sel_lo_n   (sel_lo_n),
      .sel_hi     (sel_hi),
      .read_en_n  (read_en_n),
      .write_en_n (write_en_n),
      .mode       (mode)
   );

   sram_bank_array #(
      .ADDR_W          (ADDR_W),
      .DATA_W          (DATA_W),
      .NUM_BANKS       (NUM_BANKS),
      .BANK_INTERLEAVE (BANK_INTERLEAVE)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (mode == MODE_WRITE),
      .addr    (addr),
      .wr_data (pin_data),
      .rd_data (rd_byte)
   );

   assign dq_drive = (mode == MODE_READ);
   assign dq       = dq_drive ? rd_byte : {DATA_W{1'bz}};
   assign pin_data = dq;

   // R1: high active-low select keeps the pins released
   p_float_sel_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_lo_n |-> !dq_drive);

   // R2: low active-high select keeps the pins released
   p_float_sel_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_hi |-> !dq_drive);

   // R3: both strobes inactive leaves the pins released
   p_float_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (read_en_n && write_en_n) |-> !dq_drive);

   // R4 / R9: selected read drives the pins
   p_drive_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_lo_n && sel_hi && !read_en_n && write_en_n) |-> dq_drive);

   // R5: an active write strobe always releases the pins
   p_float_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !write_en_n |-> !dq_drive);

endmodule

// File: tb/sram_dual_enable_test.sv
`timescale 1ns/1ps
module sram_dual_enable_test;

   localparam int AW    = 10;
   localparam int DW    = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          sel_lo_n, sel_hi, read_en_n, write_en_n;
   logic          tb_drv;
   logic [DW-1:0] tb_val;
   wire  [DW-1:0] dq_a;
   wire  [DW-1:0] dq_b;
   logic          drv_a, drv_b;

   int  ref_mem [DEPTH];
   bit  ref_ok  [DEPTH];
   int  n_cmp  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;

   assign dq_a = tb_drv ? tb_val : {DW{1'bz}};
   assign dq_b = tb_drv ? tb_val : {DW{1'bz}};

   sram_dual_enable #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(4), .BANK_INTERLEAVE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
      .read_en_n(read_en_n), .write_en_n(write_en_n), .dq(dq_a), .dq_drive(drv_a));

   sram_dual_enable #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(4), .BANK_INTERLEAVE(1'b0)) uut_lin (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
      .read_en_n(read_en_n), .write_en_n(write_en_n), .dq(dq_b), .dq_drive(drv_b));

   function automatic string req_of(bit l_n, bit h, bit r_n, bit w_n);
      if (l_n)       return "R1";
      else if (!h)   return "R2";
      else if (!w_n) return "R5";
      else if (!r_n) return "R4";
      else           return "R3";
   endfunction

   task automatic cmp(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one bus cycle: set inputs after a falling edge, compare, then let the rising edge act
   task automatic cyc(bit l_n, bit h, bit r_n, bit w_n, int a, int d, bit rs, string tag);
      bit is_rd, is_wr;
      @(negedge clk);
      rst_n = rs; sel_lo_n = l_n; sel_hi = h; read_en_n = r_n; write_en_n = w_n;
      addr = AW'(a);
      is_rd = !l_n && h && w_n && !r_n;
      is_wr = !l_n && h && !w_n;
      tb_drv = !is_rd;
      tb_val = DW'(d);
      #1;
      cmp("R9", {tag, " drive uut"}, int'(drv_a), int'(is_rd));
      cmp("R9", {tag, " drive uut_lin"}, int'(drv_b), int'(is_rd));
      if (is_rd) begin
         if (ref_ok[a]) begin
            cmp(tag, "read uut", int'(dq_a), ref_mem[a]);
            cmp("R8", {tag, " read uut_lin"}, int'(dq_b), ref_mem[a]);
         end
      end else begin
         cmp(req_of(l_n, h, r_n, w_n), {tag, " pins released uut"}, int'(dq_a), d & 8'hff);
         cmp(req_of(l_n, h, r_n, w_n), {tag, " pins released uut_lin"}, int'(dq_b), d & 8'hff);
      end
      @(posedge clk);
      if (is_wr && rs) begin
         ref_mem[a] = d & 8'hff;
         ref_ok[a]  = 1'b1;
      end
   endtask

   task automatic rd(int a, string tag);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, a, 0, 1'b1, tag);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = 0; ref_ok[i] = 1'b0; end
      rst_n = 1'b0; sel_lo_n = 1'b1; sel_hi = 1'b0; read_en_n = 1'b1; write_en_n = 1'b1;
      addr = '0; tb_drv = 1'b1; tb_val = '0;

      // reset state: deselected, pins released (R1)
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, 1'b1, 0, 8'h5a, 1'b0, "R1 reset");

      // fill every byte; read strobe alternates to show write priority (R5)
      for (int a = 0; a < DEPTH; a++)
         cyc(1'b0, 1'b1, a[0], 1'b0, a, (a * 37 + 11) & 255, 1'b1, "R5 fill");

      // first and last address, bank edges (R4, R8)
      rd(0, "R4"); rd(DEPTH - 1, "R4"); rd(DEPTH / 4 - 1, "R8"); rd(DEPTH / 4, "R8");
      rd(3, "R8"); rd(4, "R8");

      // read follows address with no clock delay: new address each cycle (R4)
      for (int a = 500; a < 520; a++) rd(a, "R4");

      // deselected writes must not land (R1, R2)
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 5, 8'hc3, 1'b1, "R1 blocked write");
      rd(5, "R1");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 5, 8'h3c, 1'b1, "R2 blocked write");
      rd(5, "R2");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 5, 8'h77, 1'b1, "R1 blocked write");
      rd(5, "R1");

      // output-off does nothing (R3)
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 5, 8'hee, 1'b1, "R3");
      rd(5, "R3");

      // single-byte write leaves neighbours alone (R6)
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 100, 8'h00, 1'b1, "R6 write");
      rd(99, "R6"); rd(100, "R6"); rd(101, "R6"); rd(104, "R6");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, DEPTH - 1, 8'hff, 1'b1, "R5 write oe low");
      rd(DEPTH - 1, "R5"); rd(DEPTH - 2, "R6");

      // random mixed traffic
      for (int n = 0; n < 4000; n++) begin
         int u;
         u = int'($urandom);
         cyc(u[0] & u[1], u[2] | u[3], u[4], u[5] | u[6], int'($urandom_range(DEPTH - 1, 0)),
             int'($urandom_range(255, 0)), 1'b1, "rand");
      end

      // writes blocked in reset, contents kept, read still drives (R7)
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 7, (ref_mem[7] ^ 8'hff), 1'b0, "R7 write in reset");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 7, 0, 1'b0, "R7 read in reset");
      rd(7, "R7");
      rd(8, "R7");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule